// File: doc/BRIEF.md
# Carry-Save Multiply-Accumulate Unit

This block multiplies two 8-bit two's complement operands on every cycle in which an input strobe is high. It adds the 16-bit product into a running total held in a register, so the output carries the sum of all accepted products. The adder is built as a carry-save layer followed by a merge. The layer has one half adder per bit and works on the product and the fed-back register value. The merge shifts the carry vector up one place, adds it to the sum vector and drops the carry out of the top bit, so the total wraps modulo 2^16.

A sticky flag records signed overflow. Overflow means that the product and the held total had the same sign bit and the new total came out with the other sign. A synchronous clear empties the total and drops the flag. An asynchronous active-low reset does the same at once. Typical users are filter taps and dot-product loops that stream one operand pair per clock and read the total when the sequence ends.

Top module: `csa_mac`

## Requirements
- R1: While rst_n is low, acc_q is 0 and ovf_sticky is 0, without waiting for a clock edge.
- R2: With valid high and clear low, after the next rising edge acc_q equals its old value plus x_in*y_in. Both operands are read as signed 8-bit two's complement and the sum is taken modulo 2^16.
- R3: With valid low and clear low, acc_q and ovf_sticky keep their values across the edge, whatever x_in and y_in carry.
- R4: With clear high, after the next edge acc_q is 0 and ovf_sticky is 0, whether or not valid is high. Clear takes priority and the product offered in that cycle is dropped.
- R5: An accepted product sets ovf_sticky after that edge when bit 15 of the product equals bit 15 of the old acc_q and bit 15 of the new acc_q differs from them.
- R6: Once set, ovf_sticky stays high until clear or reset, even after the total returns into range.
- R7: Adding a product whose bit 15 differs from bit 15 of the old acc_q never sets ovf_sticky.
- R8: Totals beyond the 16-bit range wrap. After an overflow, acc_q equals the exact sum of products reduced modulo 2^16.
- R9: The extreme operand pairs give exact products: -128*-128 = 16384 and -128*127 = -16256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of total and flag |
| valid | input | 1 | Accept the operand pair this cycle |
| x_in | input | 8 | First operand, signed |
| y_in | input | 8 | Second operand, signed |
| acc_q | output | 16 | Running sum of products |
| ovf_sticky | output | 1 | Sticky signed overflow flag |

## Verification
The main function is driven with several operand streams:
- A run of small positive pairs checks the basic add path.
- A mix of signs checks that the feedback subtracts correctly.
- The extreme operand values check the sign handling of the multiplier.
- Repeated large products of one sign push the total past both ends of the range. These runs tell apart a correct overflow test from one that looks only at the result sign, and they show that the total still wraps correctly afterwards.

Two further sequences check control behaviour:
- Cycles with valid low, but with operands present, must leave the total and the flag unchanged.
- A cycle with both clear and valid high shows that clear takes priority.

// File: rtl/csa_mac_pkg.sv
package csa_mac_pkg;
   // one carry-save layer output pair
   typedef struct packed {
      logic [15:0] s;
      logic [15:0] c;
   } csa_pair_t;

   function automatic logic sign_of(input logic [15:0] v);
      return v[15];
   endfunction
endpackage

// File: rtl/csa_mac_mult.sv
module csa_mac_mult #(
   parameter int OP_W       = 8,
   parameter int ACC_W      = 16,
   parameter bit SIGNED_OPS = 1'b1
) (
   input  logic [OP_W-1:0]  a,
   input  logic [OP_W-1:0]  b,
   output logic [ACC_W-1:0] prod
);
   localparam int PW = 2*OP_W;
   logic [PW-1:0] p_raw;

   generate
      if (SIGNED_OPS) begin : g_signed
         logic signed [PW-1:0] p_s;
         assign p_s   = $signed(a) * $signed(b);
         assign p_raw = p_s;
         if (ACC_W > PW) begin : g_ext
            assign prod = {{(ACC_W-PW){p_raw[PW-1]}}, p_raw};
         end else begin : g_fit
            assign prod = p_raw;
         end
      end else begin : g_unsigned
         assign p_raw = a * b;
         if (ACC_W > PW) begin : g_ext
            assign prod = {{(ACC_W-PW){1'b0}}, p_raw};
         end else begin : g_fit
            assign prod = p_raw;
         end
      end
   endgenerate
endmodule

// File: rtl/csa_mac_halfadd_layer.sv
module csa_mac_halfadd_layer #(
   parameter int W = 16
) (
   input  logic [W-1:0] p,
   input  logic [W-1:0] q,
   output logic [W-1:0] s,
   output logic [W-1:0] c
);
   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_bit
         assign s[i] = p[i] ^ q[i];
         assign c[i] = p[i] & q[i];
      end
   endgenerate
endmodule

// File: rtl/csa_mac_merge.sv
module csa_mac_merge #(
   parameter int W = 16
) (
   input  logic [W-1:0] s,
   input  logic [W-1:0] c,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [W:0] full;
   // carries weigh twice their bit; the top one leaves the word
   assign full = {1'b0, s} + {1'b0, c[W-2:0], 1'b0};
   assign sum  = full[W-1:0];
   assign cout = full[W] | c[W-1];
endmodule

// File: rtl/csa_mac.sv
module csa_mac #(
   parameter int OP_W       = 8,
   parameter int ACC_W      = 16,
   parameter bit SIGNED_OPS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             valid,
   input  logic [OP_W-1:0]  x_in,
   input  logic [OP_W-1:0]  y_in,
   output logic [ACC_W-1:0] acc_q,
   output logic             ovf_sticky
);
   localparam int MSB = ACC_W - 1;

   generate
      if (ACC_W < 2*OP_W) begin : g_bad_width
         $error("csa_mac: ACC_W must hold a full product");
      end
      if (OP_W < 2) begin : g_bad_op
         $error("csa_mac: OP_W too small");
      end
   endgenerate

   logic [ACC_W-1:0] prod, hs, hc, nxt;
   logic             top_cout, ovf_now;

   csa_mac_mult #(.OP_W(OP_W), .ACC_W(ACC_W), .SIGNED_OPS(SIGNED_OPS)) u_mult (
      .a(x_in), .b(y_in), .prod(prod)
   );

   csa_mac_halfadd_layer #(.W(ACC_W)) u_layer (
      .p(prod), .q(acc_q), .s(hs), .c(hc)
   );

   csa_mac_merge #(.W(ACC_W)) u_merge (
      .s(hs), .c(hc), .sum(nxt), .cout(top_cout)
   );

   generate
      if (SIGNED_OPS) begin : g_ovf_signed
         assign ovf_now = (prod[MSB] == acc_q[MSB]) && (nxt[MSB] != acc_q[MSB]);
      end else begin : g_ovf_unsigned
         assign ovf_now = top_cout;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q      <= '0;
         ovf_sticky <= 1'b0;
      end else if (clear) begin
         acc_q      <= '0;
         ovf_sticky <= 1'b0;
      end else if (valid) begin
         acc_q      <= nxt;
         ovf_sticky <= ovf_sticky | ovf_now;
      end
   end
endmodule

// File: rtl/csa_mac_chk.sv
module csa_mac_chk #(
   parameter int OP_W  = 8,
   parameter int ACC_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clear,
   input logic             valid,
   input logic [OP_W-1:0]  x_in,
   input logic [OP_W-1:0]  y_in,
   input logic [ACC_W-1:0] acc_q,
   input logic             ovf_sticky
);
   logic prod_neg;
   assign prod_neg = (x_in[OP_W-1] ^ y_in[OP_W-1]) && (x_in != '0) && (y_in != '0);

   // R3
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !valid) |=> ($stable(acc_q) && $stable(ovf_sticky)));

   // R4
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (acc_q == '0 && !ovf_sticky));

   // R6
   sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_sticky && !clear) |=> ovf_sticky);

   // R7
   mixed_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !clear && !ovf_sticky && (prod_neg != acc_q[ACC_W-1])) |=> !ovf_sticky);

   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_state_chk: assert (acc_q == '0 && !ovf_sticky);
      end
   end
endmodule

bind csa_mac csa_mac_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clear(clear), .valid(valid),
   .x_in(x_in), .y_in(y_in), .acc_q(acc_q), .ovf_sticky(ovf_sticky)
);

// File: tb/csa_mac_bench.sv
module csa_mac_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clear = 1'b0;
   logic        valid = 1'b0;
   logic [7:0]  x_in = '0;
   logic [7:0]  y_in = '0;
   logic [15:0] acc_q;
   logic        ovf_sticky;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   logic [16:0] exp_q[$];
   string       tag_q[$];

   logic [15:0] m_acc = '0;
   logic        m_ovf = 1'b0;

   csa_mac u_csa_mac (
      .clk(clk), .rst_n(rst_n), .clear(clear), .valid(valid),
      .x_in(x_in), .y_in(y_in), .acc_q(acc_q), .ovf_sticky(ovf_sticky)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got q=%h ovf=%b, expected q=%h ovf=%b",
                  tag, act[15:0], act[16], exp[15:0], exp[16]);
      end
   endtask

   // driver: apply one cycle and push the expected result
   task automatic step(input string tag, input logic c, input logic v,
                       input int xa, input int yb);
      logic signed [15:0] p;
      logic [15:0] s;
      @(negedge clk);
      clear = c; valid = v; x_in = xa[7:0]; y_in = yb[7:0];
      p = 16'($signed(xa[7:0]) * $signed(yb[7:0]));
      if (c) begin
         m_acc = '0; m_ovf = 1'b0;
      end else if (v) begin
         s = m_acc + p;
         if (p[15] == m_acc[15] && s[15] != m_acc[15]) m_ovf = 1'b1;
         m_acc = s;
      end
      exp_q.push_back({m_ovf, m_acc});
      tag_q.push_back(tag);
   endtask

   // monitor: compare just after each edge
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         logic [16:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, {ovf_sticky, acc_q}, e);
      end
   end

   initial begin
      #(CLK_PERIOD*100000);
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #3;
      check("R1 reset", {ovf_sticky, acc_q}, 17'h0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      // R2: small positives, then mixed signs
      step("R2 pos", 0, 1, 3, 5);
      step("R2 pos", 0, 1, 7, 9);
      step("R2 pos", 0, 1, 100, 2);
      step("R2 mixed", 0, 1, -20, 30);
      step("R2 mixed", 0, 1, 15, -4);
      step("R2 mixed", 0, 1, -7, -8);
      // R3: idle with garbage on operands
      step("R3 hold", 0, 0, 127, 127);
      step("R3 hold", 0, 0, -128, 55);
      // R9: extremes
      step("R4 clear", 1, 0, 0, 0);
      step("R9 neg*neg", 0, 1, -128, -128);
      step("R9 neg*pos", 0, 1, -128, 127);
      // R4: clear wins over valid
      step("R4 clear wins", 1, 1, 127, 127);
      // R5/R8: positive overflow on third add
      step("R5 pos run", 0, 1, 127, 127);
      step("R5 pos run", 0, 1, 127, 127);
      step("R5 pos ovf", 0, 1, 127, 127);
      step("R8 wrap", 0, 1, 127, 127);
      // R6: return into range, flag must stay
      step("R6 sticky", 0, 1, -128, 127);
      step("R6 sticky", 0, 1, -128, 127);
      step("R6 sticky", 0, 1, -128, 127);
      step("R6 idle", 0, 0, 1, 1);
      step("R4 clear", 1, 0, 0, 0);
      // R7: alternating signs near the edges never flag
      step("R7 mixed", 0, 1, 127, 127);
      step("R7 mixed", 0, 1, 127, 127);
      step("R7 mixed", 0, 1, -128, 127);
      step("R7 mixed", 0, 1, 127, 127);
      step("R7 mixed", 0, 1, -100, 100);
      // R5: negative overflow
      step("R4 clear", 1, 0, 0, 0);
      step("R5 neg run", 0, 1, -128, 127);
      step("R5 neg run", 0, 1, -128, 127);
      step("R5 neg ovf", 0, 1, -128, 127);
      step("R8 wrap neg", 0, 1, 120, -90);
      @(negedge clk);
      valid = 1'b0; clear = 1'b0;
      @(negedge clk);
      // R1: asynchronous reset mid-cycle
      #2 rst_n = 1'b0;
      #1 check("R1 async", {ovf_sticky, acc_q}, 17'h0);
      m_acc = '0; m_ovf = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      step("R2 after reset", 0, 1, 2, 3);
      @(negedge clk);
      valid = 1'b0;
      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule